// File: doc/BRIEF.md
# PWM Timebase: Beat Divider and Phase Accumulator

This block supplies the common timebase shared by every channel of a multi-channel pulse width modulator. A programmable divider turns the input clock into a slower beat. Each beat advances a 16-bit phase accumulator, which always expresses the position within the current PWM cycle as a fraction of 2^16.

The size of each phase step is a power of two chosen by a logarithmic resolution setting. With resolution setting `res`, one PWM cycle takes 2^(res+1) beats. Only the top (res+1) bits of the phase then carry information. When a beat carries the accumulator back through zero, a one-clock cycle-end pulse marks the start of a new PWM cycle. Per-channel comparators take the phase and the pulse to place their edges.

When the run enable is low, the divider and the accumulator both stay at zero. Dropping the enable therefore restarts the timebase from a known state.

Top module: `pwm_timebase`

## Requirements
- R1: While `rst` is high, `phase_o` is 0 and `cycle_end_o` is 0 after each clock edge, whatever the other inputs are.
- R2: With `run_en` high and divider setting D, `phase_o` changes exactly once every D+1 clocks. The first change follows the (D+1)-th rising edge at which `run_en` is high. Between beats `phase_o` holds its value.
- R3: Each beat adds 2^(15-res_sel) to `phase_o`, modulo 2^16. `res_sel` is 0 to 15, so the step runs from 0x8000 down to 1.
- R4: `cycle_end_o` is 1 for exactly the clock in which `phase_o` has just wrapped to 0 on a beat. With `run_en` held high, this happens once every 2^(res_sel+1)*(D+1) clocks.
- R5: Any clock edge that sees `run_en` low returns both the divider count and `phase_o` to 0 and clears `cycle_end_o`. After `run_en` goes high again, the first beat takes a full D+1 clocks.
- R6: If `div_sel` is lowered below the current divider count, the very next clock edge is a beat and the count restarts from zero. Later beats come every new D+1 clocks.
- R7: `cycle_end_o` is never high on two consecutive clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Run enable; low holds the timebase at zero |
| res_sel | input | 4 | Logarithmic resolution; one cycle is 2^(res_sel+1) beats |
| div_sel | input | 27 | Divider setting D; one beat every D+1 clocks |
| phase_o | output | 16 | Current phase in 2^-16 fractions of a cycle |
| cycle_end_o | output | 1 | One-clock pulse when the phase wraps to zero |

## Verification
The bench predicts the phase from the number of enabled edges, with D+1 clocks per beat. If the first beat came one clock early or late, every phase would be off by one step. The extreme resolutions are checked separately. With res_sel 0 the phase wraps every second beat, and with res_sel 15 the step is 1, so a shift-amount error at either end shows up as a wrong phase. Lowering the divider below the running count checks that an equality compare would run away instead of beating on the next edge. Dropping the enable mid-count checks that the divider restarts as well as the phase. Counting pulses over a window catches a cycle-end pulse that is stretched or repeated.

// File: rtl/pwmtb_pkg.sv
package pwmtb_pkg;
    localparam int PHASE_W = 16;
    localparam int RES_W   = 4;
    localparam int DIV_W   = 27;

    // Handoff from the divider to the accumulator
    typedef struct packed {
        logic run;
        logic beat;
    } tick_t;
endpackage

// File: rtl/pwmtb_divider.sv
module pwmtb_divider #(
    parameter int DivW = pwmtb_pkg::DIV_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               run,
    input  logic [DivW-1:0]    limit,
    output pwmtb_pkg::tick_t   tick_o
);
    logic [DivW-1:0] cnt_q;
    logic            at_end;

    // A greater-or-equal compare keeps a lowered limit from letting the count run away
    assign at_end = (cnt_q >= limit);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (at_end) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick_o.run  = run;
    assign tick_o.beat = run && at_end;

    p_idle_zero_r5: assert property (@(posedge clk) disable iff (rst)
        !run |=> (cnt_q == '0));

    p_no_runaway_r6: assert property (@(posedge clk) disable iff (rst)
        (run && (cnt_q > limit)) |=> (cnt_q == '0));
endmodule

// File: rtl/pwmtb_phase.sv
module pwmtb_phase #(
    parameter int PhaseW = pwmtb_pkg::PHASE_W,
    parameter int ResW   = pwmtb_pkg::RES_W
) (
    input  logic               clk,
    input  logic               rst,
    input  pwmtb_pkg::tick_t   tick_i,
    input  logic [ResW-1:0]    res,
    output logic [PhaseW-1:0]  phase_o,
    output logic               end_o
);
    localparam int TopBit = PhaseW - 1;

    logic [PhaseW-1:0] phase_q;
    logic              end_q;
    logic [PhaseW-1:0] step;
    logic [PhaseW:0]   sum;

    always_comb begin
        if (int'(res) >= TopBit) begin
            step = PhaseW'(1);
        end else begin
            step = PhaseW'(1) << (TopBit - int'(res));
        end
    end

    assign sum = {1'b0, phase_q} + {1'b0, step};

    always_ff @(posedge clk) begin
        if (rst || !tick_i.run) begin
            phase_q <= '0;
            end_q   <= 1'b0;
        end else begin
            end_q <= tick_i.beat && sum[PhaseW];
            if (tick_i.beat) begin
                phase_q <= sum[PhaseW-1:0];
            end
        end
    end

    assign phase_o = phase_q;
    assign end_o   = end_q;

    p_hold_between_beats_r2: assert property (@(posedge clk) disable iff (rst)
        (tick_i.run && !tick_i.beat) |=> $stable(phase_q));

    p_end_at_zero_r4: assert property (@(posedge clk) disable iff (rst)
        end_q |-> (phase_q == '0));

    p_end_single_r7: assert property (@(posedge clk) disable iff (rst)
        end_q |=> !end_q);
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
    parameter int PhaseW = pwmtb_pkg::PHASE_W,
    parameter int ResW   = pwmtb_pkg::RES_W,
    parameter int DivW   = pwmtb_pkg::DIV_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               run_en,
    input  logic [ResW-1:0]    res_sel,
    input  logic [DivW-1:0]    div_sel,
    output logic [PhaseW-1:0]  phase_o,
    output logic               cycle_end_o
);
    pwmtb_pkg::tick_t tick;

    pwmtb_divider #(.DivW(DivW)) div_i (
        .clk    (clk),
        .rst    (rst),
        .run    (run_en),
        .limit  (div_sel),
        .tick_o (tick)
    );

    pwmtb_phase #(.PhaseW(PhaseW), .ResW(ResW)) acc_i (
        .clk     (clk),
        .rst     (rst),
        .tick_i  (tick),
        .res     (res_sel),
        .phase_o (phase_o),
        .end_o   (cycle_end_o)
    );

    // R3: the step is never zero, so every beat must move the phase
    p_beat_moves_r3: assert property (@(posedge clk) disable iff (rst)
        (tick.beat && run_en) |=> (phase_o != $past(phase_o)));

    // R5: an edge with the enable low leaves the outputs at zero
    p_disabled_zero_r5: assert property (@(posedge clk) disable iff (rst)
        !run_en |=> (phase_o == '0 && !cycle_end_o));
endmodule

// File: tb/pwm_timebase_tb.sv
module pwm_timebase_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        run_en;
    logic [3:0]  res_sel;
    logic [26:0] div_sel;
    logic [15:0] phase_o;
    logic        cycle_end_o;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    pwm_timebase dut_i (
        .clk         (clk),
        .rst         (rst),
        .run_en      (run_en),
        .res_sel     (res_sel),
        .div_sel     (div_sel),
        .phase_o     (phase_o),
        .cycle_end_o (cycle_end_o)
    );

    typedef struct packed {
        logic [3:0]  res;
        logic [26:0] div;
        logic [15:0] n;
    } vec_t;

    localparam int NVEC = 7;
    localparam vec_t VEC [NVEC] = '{
        '{4'd7,  27'd0, 16'd5},
        '{4'd7,  27'd3, 16'd40},
        '{4'd0,  27'd0, 16'd2},
        '{4'd15, 27'd1, 16'd9},
        '{4'd3,  27'd2, 16'd48},
        '{4'd2,  27'd4, 16'd13},
        '{4'd0,  27'd0, 16'd3}
    };

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    function automatic logic [15:0] exp_phase(input int res, input int div, input int n);
        int beats;
        beats = n / (div + 1);
        return 16'((beats * (1 << (15 - res))) & 16'hFFFF);
    endfunction

    function automatic logic exp_end(input int res, input int div, input int n);
        int beats;
        beats = n / (div + 1);
        return (n % (div + 1) == 0) && (beats > 0) && (beats % (1 << (res + 1)) == 0);
    endfunction

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; run_en = 1'b1; res_sel = 4'd0; div_sel = 27'd0;
        repeat (5) @(negedge clk);
        check("R1 phase in reset", 32'(phase_o), 32'd0);
        check("R1 cycle_end in reset", 32'(cycle_end_o), 32'd0);
        rst = 1'b0; run_en = 1'b0;
        @(negedge clk);

        // Vector table: R2 beat timing, R3 step size, R4 wrap pulse
        for (int i = 0; i < NVEC; i++) begin
            run_en = 1'b0;
            @(negedge clk);
            res_sel = VEC[i].res; div_sel = VEC[i].div; run_en = 1'b1;
            repeat (int'(VEC[i].n)) @(negedge clk);
            check($sformatf("R2 R3 vector %0d phase", i), 32'(phase_o),
                  32'(exp_phase(int'(VEC[i].res), int'(VEC[i].div), int'(VEC[i].n))));
            check($sformatf("R4 vector %0d cycle_end", i), 32'(cycle_end_o),
                  32'(exp_end(int'(VEC[i].res), int'(VEC[i].div), int'(VEC[i].n))));
        end

        // R5: enable low holds everything at zero
        run_en = 1'b0; res_sel = 4'd7; div_sel = 27'd0;
        repeat (20) @(negedge clk);
        check("R5 idle phase", 32'(phase_o), 32'd0);

        // R5: clearing mid-count restarts the divider as well
        div_sel = 27'd5; run_en = 1'b1;
        repeat (9) @(negedge clk);
        check("R5 before clear", 32'(phase_o), 32'h0100);
        run_en = 1'b0;
        @(negedge clk);
        check("R5 cleared phase", 32'(phase_o), 32'd0);
        run_en = 1'b1;
        repeat (5) @(negedge clk);
        check("R5 no early beat", 32'(phase_o), 32'd0);
        @(negedge clk);
        check("R5 first beat full period", 32'(phase_o), 32'h0100);

        // R6: lowering the divider below the running count
        run_en = 1'b0;
        @(negedge clk);
        res_sel = 4'd7; div_sel = 27'd20; run_en = 1'b1;
        repeat (10) @(negedge clk);
        check("R6 before change", 32'(phase_o), 32'd0);
        div_sel = 27'd3;
        @(negedge clk);
        check("R6 immediate beat", 32'(phase_o), 32'h0100);
        repeat (3) @(negedge clk);
        check("R6 hold after restart", 32'(phase_o), 32'h0100);
        @(negedge clk);
        check("R6 next beat", 32'(phase_o), 32'h0200);

        // R4, R7: pulse period and width over a window
        run_en = 1'b0;
        @(negedge clk);
        res_sel = 4'd1; div_sel = 27'd1; run_en = 1'b1;
        begin
            int highs;
            int doubles;
            logic prev;
            highs = 0; doubles = 0; prev = 1'b0;
            for (int k = 0; k < 40; k++) begin
                @(negedge clk);
                if (cycle_end_o) highs++;
                if (cycle_end_o && prev) doubles++;
                prev = cycle_end_o;
            end
            check("R4 pulses in 40 clocks", 32'(highs), 32'd5);
            check("R7 no back-to-back pulse", 32'(doubles), 32'd0);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule